// File: doc/BRIEF.md
# Shadowed BCD Real-Time Clock Registers

This block keeps calendar time in a chain of BCD counters and shows it on a small synchronous register bus through a second, separate set of visible registers. A one-second tick from an external prescaler advances the counters. In the cycle after each tick, the whole counter set is copied into the visible registers in one step. A read therefore never sees a carry that has only partly propagated.

Software controls the visible copy with two bits in a control register. The freeze bit stops the refresh so a multi-byte read stays consistent, while the counters keep running. The load bit also stops the refresh and opens the time registers to bus writes. Clearing the load bit pushes the visible values into the counters. A separate stop bit in the seconds register halts the counters themselves, and it can be written at any time.

Top module: `rtc_shadow_regs`

## Requirements
- R1: After reset, the control register reads 0x00. The visible and counter time is 00:00:00, day-of-week 1, date 01, month 01, year 00 and century 20, and the stop bit is 0.
- R2: Register map on the 4-bit address. Address 8 is control: bit 7 is load and bit 6 is freeze, and all other bits read 0. Addresses 9 to 15 are seconds (bit 7 is stop), minutes, hours, day-of-week, date, month and year. Address 1 is century. Every time field is packed BCD, and any other address reads 0x00.
- R3: On a tick with stop clear, the counters advance one second with BCD carries. Seconds and minutes wrap 59 to 00, and hours wrap 23 to 00. Day-of-week wraps 7 to 1 when hours wrap. Month wraps 12 to 01. Year wraps 99 to 00 and carries into the century, which wraps 99 to 00.
- R4: Date wraps to 01 after the last day of its month: 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, and for month 2 either 29 (year value divisible by four) or 28.
- R5: When neither freeze nor load is set at a tick, all visible time registers take the new counter values together, one clock after the tick cycle.
- R6: While freeze is 1, the visible registers hold their value and the counters keep counting. After freeze is cleared, the visible registers do not change until the next tick. At that tick they show the current count.
- R7: A refresh started by a tick completes even if freeze or load is written to 1 in the cycle after the tick.
- R8: While load is 1, bus writes to the time registers update the visible registers. While load is 0, such writes have no effect on them, except for the stop bit.
- R9: Writing load from 1 to 0 copies the visible time registers into the counters at that clock edge. The next refresh comes with the next tick.
- R10: Stop can be written whether or not load is set, and it reads back in seconds bit 7. While it is 1, the counters do not advance on ticks. After it is cleared, the next tick advances them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable, one write per cycle |
| rdata_o | output | 8 | Read data of the addressed register (combinational) |

## Verification
The assertions assume that every value loaded through the load path is legal BCD within its field range, with the date valid for its month. Otherwise the wrap checks on the counters would not be meaningful. They also assume that no time register is written in the cycle a tick-triggered refresh lands. The stimulus meets both assumptions: every load is built from binary values in range and converted to BCD in the bench, and bus accesses never coincide with the refresh cycle that follows a tick. The sweep covers every month of every year value at 23:59:59 on the last day of the month, plus more than an hour of consecutive seconds.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_FIELDS = 8;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  localparam logic [3:0] ADDR_CTRL = 4'd8;
  localparam logic [3:0] ADDR_SEC  = 4'd9;
  localparam logic [3:0] ADDR_CENT = 4'd1;

  typedef logic [NUM_FIELDS-1:0][7:0] rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic year_is_leap(input logic [7:0] y);
    logic [6:0] bin;
    bin = {3'b0, y[7:4]} * 7'd10 + {3'b0, y[3:0]};
    year_is_leap = (bin[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      month_last = year_is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
      default:                    month_last = 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_min(input int f);
    field_min = (f == F_DAY || f == F_DATE || f == F_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] field_max(input int f);
    case (f)
      F_SEC, F_MIN:   field_max = 8'h59;
      F_HOUR:         field_max = 8'h23;
      F_DAY:          field_max = 8'h07;
      F_DATE:         field_max = 8'h31;
      F_MON:          field_max = 8'h12;
      default:        field_max = 8'h99;
    endcase
  endfunction

  function automatic logic [7:0] field_mask(input int f);
    case (f)
      F_SEC, F_MIN:   field_mask = 8'h7F;
      F_HOUR, F_DATE: field_mask = 8'h3F;
      F_DAY:          field_mask = 8'h07;
      F_MON:          field_mask = 8'h1F;
      default:        field_mask = 8'hFF;
    endcase
  endfunction

  // address -> field index; -1 when not a time register
  function automatic int addr_field(input logic [3:0] a);
    if (a == ADDR_CENT) addr_field = F_CENT;
    else if (a >= ADDR_SEC) addr_field = int'(a) - int'(ADDR_SEC);
    else addr_field = -1;
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] MIN_VAL = 8'h00,
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic [7:0] max_i,
  output logic [7:0] val_o,
  output logic       at_max_o
);
  import rtc_pkg::*;

  logic [7:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST_VAL;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= (val_q == max_i) ? MIN_VAL : bcd_inc(val_q);
  end

  assign val_o    = val_q;
  assign at_max_o = (val_q == max_i);

  // R3
  wrap_to_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && val_q == max_i) |=> (val_q == MIN_VAL));
endmodule

// File: rtl/rtc_counter_chain.sv
module rtc_counter_chain #(
  parameter logic [7:0] RST_CENTURY = 8'h20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  input  logic               load_i,
  input  rtc_pkg::rtc_time_t load_val_i,
  output rtc_pkg::rtc_time_t time_o
);
  import rtc_pkg::*;

  logic [NUM_FIELDS-1:0]      at_max;
  logic [NUM_FIELDS-1:0]      inc;
  logic [NUM_FIELDS-1:0][7:0] max_v;

  // carry terms built only from at_max flags, so no combinational loop
  logic c_min, c_hour, c_day, c_mon, c_year, c_cent;
  assign c_min  = adv_i  & at_max[F_SEC];
  assign c_hour = c_min  & at_max[F_MIN];
  assign c_day  = c_hour & at_max[F_HOUR];
  assign c_mon  = c_day  & at_max[F_DATE];
  assign c_year = c_mon  & at_max[F_MON];
  assign c_cent = c_year & at_max[F_YEAR];
  assign inc = {c_cent, c_year, c_mon, c_day, c_day, c_hour, c_min, adv_i};

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [7:0] RST_V = (i == F_CENT) ? RST_CENTURY : field_min(i);
    if (i == F_DATE) begin : g_dyn
      assign max_v[i] = month_last(time_o[F_MON], time_o[F_YEAR]);
    end else begin : g_fix
      assign max_v[i] = field_max(i);
    end
    rtc_bcd_field #(.MIN_VAL(field_min(i)), .RST_VAL(RST_V)) u_fld (
      .clk_i, .rst_ni,
      .inc_i(inc[i]), .load_i,
      .load_val_i(load_val_i[i]),
      .max_i(max_v[i]),
      .val_o(time_o[i]),
      .at_max_o(at_max[i])
    );
  end

  // R10
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(time_o));
  // R9
  load_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (time_o == $past(load_val_i)));
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs #(
  parameter logic [7:0] RST_CENTURY = 8'h20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       we_i,
  output logic [7:0] rdata_o
);
  import rtc_pkg::*;

  rtc_time_t cnt;
  rtc_time_t shadow_q;
  logic      read_q, write_q, stop_q, xfer_pend_q;
  logic      halt, commit, adv;
  int        wr_field;

  assign halt     = read_q | write_q;
  assign wr_field = addr_field(addr_i);
  assign commit   = we_i && (addr_i == ADDR_CTRL) && write_q && !wdata_i[7];
  assign adv      = tick_i && !stop_q;

  rtc_counter_chain #(.RST_CENTURY(RST_CENTURY)) u_chain (
    .clk_i, .rst_ni,
    .adv_i(adv),
    .load_i(commit),
    .load_val_i(shadow_q),
    .time_o(cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      read_q      <= 1'b0;
      write_q     <= 1'b0;
      stop_q      <= 1'b0;
      xfer_pend_q <= 1'b0;
    end else begin
      xfer_pend_q <= tick_i && !halt;
      if (we_i && addr_i == ADDR_CTRL) begin
        write_q <= wdata_i[7];
        read_q  <= wdata_i[6];
      end
      if (we_i && addr_i == ADDR_SEC) stop_q <= wdata_i[7];
    end
  end

  // a pending refresh always completes; it wins over a same-cycle bus write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_FIELDS; i++)
        shadow_q[i] <= (i == F_CENT) ? RST_CENTURY : field_min(i);
    end else if (xfer_pend_q) begin
      shadow_q <= cnt;
    end else if (we_i && write_q && wr_field >= 0) begin
      shadow_q[wr_field] <= wdata_i & field_mask(wr_field);
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == ADDR_CTRL)     rdata_o = {write_q, read_q, 6'b0};
    else if (addr_i == ADDR_SEC) rdata_o = {stop_q, shadow_q[F_SEC][6:0]};
    else if (wr_field >= 0)      rdata_o = shadow_q[wr_field];
  end

  // R5 R7
  refresh_complete_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_pend_q |=> (shadow_q == $past(cnt)));
  // R8
  shadow_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!write_q && !xfer_pend_q) |=> $stable(shadow_q));
  // R6
  halt_no_refresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !tick_i) |=> !xfer_pend_q);
  // R10
  stop_freezes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !commit) |=> $stable(cnt));
endmodule

// File: tb/tb_rtc_shadow_regs.sv
module tb_rtc_shadow_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic       we = 1'b0;
  logic [7:0] rdata;

  int errors = 0;
  int checks = 0;
  int m[8];       // counter model, binary: sec min hour day date mon year cent
  logic m_stop = 1'b0;

  always #10 clk = ~clk;

  rtc_shadow_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .addr_i(addr), .wdata_i(wdata), .we_i(we), .rdata_o(rdata)
  );

  function automatic logic [7:0] bcd(input int x);
    return 8'(((x / 10) << 4) | (x % 10));
  endfunction

  function automatic logic [3:0] faddr(input int i);
    return (i == 7) ? 4'd1 : 4'(9 + i);
  endfunction

  function automatic int mlen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic model_adv();
    if (m_stop) return;
    m[0]++;
    if (m[0] == 60) begin m[0] = 0; m[1]++; end
    if (m[1] == 60) begin m[1] = 0; m[2]++; end
    if (m[2] == 24) begin
      m[2] = 0;
      m[3] = (m[3] == 7) ? 1 : m[3] + 1;
      m[4]++;
      if (m[4] > mlen(m[5], m[6])) begin m[4] = 1; m[5]++; end
      if (m[5] == 13) begin m[5] = 1; m[6]++; end
      if (m[6] == 100) begin m[6] = 0; m[7] = (m[7] + 1) % 100; end
    end
  endtask

  // tick pulse, then one more cycle so a refresh has landed
  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    model_adv();
  endtask

  task automatic check_vis(input string req, input int v[8]);
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(faddr(i), d);
      check(req, d, bcd(v[i]) | ((i == 0 && m_stop) ? 8'h80 : 8'h00));
    end
  endtask

  task automatic set_time(input int v[8]);
    wr(4'd8, 8'h80);
    for (int i = 0; i < 8; i++) wr(faddr(i), bcd(v[i]) | ((i == 0 && m_stop) ? 8'h80 : 8'h00));
    wr(4'd8, 8'h00);
    m = v;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int snap[8];
    int v[8];
    m = '{0, 0, 0, 1, 1, 1, 0, 20};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 control and unused address
    rd(4'd8, d); check("R1 ctrl", d, 8'h00);
    check_vis("R1 reset time", m);
    rd(4'd0, d); check("R2 unused addr", d, 8'h00);

    // R3 R5 consecutive seconds across more than an hour
    for (int k = 0; k < 3700; k++) begin
      do_tick();
      check_vis("R3 R5 running", m);
    end

    // R4 R3 last day of every month of every year value at 23:59:59
    for (int y = 0; y < 100; y++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        v = '{59, 59, 23, (y * 12 + mo) % 7 + 1, mlen(mo, y), mo, y, (y == 99) ? 99 : 19};
        set_time(v);
        do_tick();
        check_vis("R4 R3 month end", m);
      end
    end

    // R9 commit visible before a tick, counters loaded after
    v = '{30, 15, 10, 3, 14, 6, 24, 20};
    set_time(v);
    check_vis("R9 loaded visible", m);
    do_tick();
    check_vis("R9 counters committed", m);

    // R6 freeze holds visible while counters run
    wr(4'd8, 8'h40);
    rd(4'd8, d); check("R2 R6 freeze bit", d, 8'h40);
    snap = m;
    repeat (3) do_tick();
    check_vis("R6 frozen", snap);
    wr(4'd8, 8'h00);
    check_vis("R6 held until tick", snap);
    do_tick();
    check_vis("R6 resumed with running count", m);

    // R7 freeze written right after a tick: refresh still completes
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; addr = 4'd8; wdata = 8'h40; we = 1'b1;
    @(negedge clk); we = 1'b0;
    model_adv();
    check_vis("R7 refresh completed", m);
    snap = m;
    do_tick();
    check_vis("R7 then frozen", snap);
    wr(4'd8, 8'h00);
    do_tick();
    check_vis("R7 after release", m);

    // R8 time write ignored while load bit clear
    wr(4'd10, 8'h33);
    wr(4'd1, 8'h55);
    check_vis("R8 write ignored", m);

    // R10 stop without load bit
    wr(4'd9, 8'h80); m_stop = 1'b1;
    rd(4'd9, d); check("R10 stop readback", d, bcd(m[0]) | 8'h80);
    repeat (4) do_tick();
    check_vis("R10 stopped", m);
    wr(4'd9, 8'h00); m_stop = 1'b0;
    do_tick();
    check_vis("R10 resumed", m);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule